// File: doc/BRIEF.md
# Byte-Lane DRAM Strobe Decoder Model

This block is a clock-sampled, synthesizable model of the memory side of a 16-bit-wide dynamic RAM with two byte-lane column strobes. It serves as a self-checking target for a DRAM controller. On every clock edge it samples the row strobe, both column strobes, the write and output enables and the multiplexed address. It then works out from the order of those edges what kind of cycle is running, moves data to or from a small internal array, and drives or releases the data bus.

The two column strobes act as one merged strobe: it becomes active when either lane strobe goes low and ends only when both are high again. Each lane strobe still decides whether its own byte is written. The row address is taken when the row strobe falls, and the column address when the merged strobe falls. The array index is made from the low bits of both. A column strobe that is already low when the row strobe falls marks a refresh that takes its row from an internal counter. A row strobe falling on its own is a refresh of the row given on the address pins. This second case also opens the row for a later access.

All strobes and enables are active low. All outputs are registered, so every result appears one clock edge after the edge that sampled its cause.

Top module: `byte_lane_dram`

## Requirements
- R1: The merged column strobe is low while either lane strobe is low. A read starts at the first lane strobe fall, and the bus stays driven while at least one lane strobe is still low.
- R2: The row address is latched when the row strobe falls with the merged strobe high. The column is taken when the merged strobe falls while the row is open. The array word index is {row[ROW_IDX_W-1:0], col[COL_IDX_W-1:0]}.
- R3: A merged strobe fall with write enable high is a read. cyc_kind becomes 1, dq_out holds the addressed word, and dq_oe is 1 while oe_n is low.
- R4: A merged strobe fall with write enable already low is an early write. cyc_kind becomes 2, dq_in is written, and dq_oe stays 0 for the whole cycle.
- R5: A write enable fall during a read is a late write. cyc_kind becomes 3, dq_in is captured at that sample into the column latched by the read, and the bus is released.
- R6: A write changes only the bytes whose lane strobe is low at the capture sample (casl_n for bits 7:0, cash_n for bits 15:8). The other byte keeps its value.
- R7: A row strobe fall while the merged strobe is already low is a counter refresh. cyc_kind becomes 4, refr_row takes the counter value, and ref_cnt increments by exactly one.
- R8: A row strobe fall with the merged strobe high reports cyc_kind 5 (row-address refresh, or row open awaiting access). refr_row takes the address pins and ref_cnt does not change.
- R9: When oe_n is sampled high, dq_oe is 0 at the next edge.
- R10: A read stays driven until the row strobe and both lane strobes are all sampled high. After that sample, dq_oe is 0.
- R11: If the row strobe pulses high and then low while the merged strobe stays low after a read, a counter refresh happens and the read data stays on the bus.
- R12: proto_err is set when a late-write capture happens while oe_n is low and the bus is being driven. It stays set until reset.
- R13: After reset: cyc_kind 0, dq_oe 0, dq_out 0, ref_cnt 0, refr_row 0, proto_err 0, and the array holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-byte column strobe, active low |
| cash_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the controller |
| dq_out | output | DQ_W | Read data toward the controller |
| dq_oe | output | 1 | High while the model drives the bus |
| cyc_kind | output | 3 | Cycle class: 0 idle, 1 read, 2 early write, 3 late write, 4 counter refresh, 5 row refresh/open |
| ref_cnt | output | ADDR_W | Internal refresh row counter |
| refr_row | output | ADDR_W | Row used by the most recent refresh-type row strobe fall |
| proto_err | output | 1 | Sticky flag for a write capture during an active drive |

## Verification
Every output is registered from the same edge that samples the strobes. The class, read data, refresh row and counter are therefore due one edge after the sample that holds the causing strobe edge. Release of the bus after oe_n goes high or after the cycle ends is also due at that edge. The bench changes inputs 1 ns after a rising edge and reads results 1 ns after the next rising edge, so each check lands exactly on the edge where the result is due. Written data is checked by a later read cycle, which returns the stored word one edge after its column strobe fall.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

  typedef enum logic [2:0] {
    K_IDLE     = 3'd0,
    K_READ     = 3'd1,
    K_EARLY_WR = 3'd2,
    K_LATE_WR  = 3'd3,
    K_CBR      = 3'd4,
    K_ROW_ONLY = 3'd5
  } cyc_kind_e;

  // merged column strobe: low while any lane strobe is low
  function automatic logic merge_cas(input logic lo_n, input logic hi_n);
    return lo_n & hi_n;
  endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic casl_n,
  input  logic cash_n,
  input  logic we_n,
  output logic cas_n,
  output logic cas_prev_n,
  output logic ras_fall,
  output logic cas_fall,
  output logic we_fall,
  output logic cycle_end
);
  import dram_model_pkg::*;

  logic ras_q, cas_q, we_q;

  assign cas_n = merge_cas(casl_n, cash_n);
  assign cas_prev_n = cas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign ras_fall  = ras_q & ~ras_n;
  // a column access needs the row already open before and at this sample
  assign cas_fall  = cas_q & ~cas_n & ~ras_q & ~ras_n;
  assign we_fall   = we_q & ~we_n;
  assign cycle_end = ras_n & cas_n;

endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier #(
  parameter int ADDR_W    = 8,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  localparam int IDX_W    = ROW_IDX_W + COL_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              cas_prev_n,
  input  logic              casl_n,
  input  logic              cash_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic              we_fall,
  input  logic              cycle_end,
  output logic              rd_evt,
  output logic              ew_evt,
  output logic              lw_evt,
  output logic              cbr_evt,
  output logic              wr_en,
  output logic [1:0]        wr_lanes,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              dq_oe,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] ref_cnt,
  output logic [ADDR_W-1:0] refr_row,
  output logic              proto_err
);
  import dram_model_pkg::*;

  logic [ADDR_W-1:0] row_q, col_q;
  cyc_kind_e         kind_q, kind_d;
  logic              read_act_q, read_act_d, open_evt;

  function automatic logic [IDX_W-1:0] word_idx(input logic [ADDR_W-1:0] r,
                                                input logic [ADDR_W-1:0] c);
    return {r[ROW_IDX_W-1:0], c[COL_IDX_W-1:0]};
  endfunction

  assign cbr_evt  = ras_fall & ~cas_n & ~cas_prev_n;
  assign open_evt = ras_fall & cas_prev_n;
  assign rd_evt   = cas_fall & we_n;
  assign ew_evt   = cas_fall & ~we_n;
  assign lw_evt   = read_act_q & we_fall & ~cas_fall & ~cas_n & ~ras_n;

  assign wr_en    = ew_evt | lw_evt;
  assign wr_lanes = {~cash_n, ~casl_n};
  assign wr_idx   = ew_evt ? word_idx(row_q, addr) : word_idx(row_q, col_q);
  assign rd_idx   = word_idx(row_q, addr);

  always_comb begin
    if (rd_evt)                            read_act_d = 1'b1;
    else if (ew_evt || lw_evt || cycle_end) read_act_d = 1'b0;
    else                                   read_act_d = read_act_q;
  end

  always_comb begin
    kind_d = kind_q;
    if (cbr_evt)       kind_d = K_CBR;
    else if (open_evt) kind_d = K_ROW_ONLY;
    else if (rd_evt)   kind_d = K_READ;
    else if (ew_evt)   kind_d = K_EARLY_WR;
    else if (lw_evt)   kind_d = K_LATE_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q      <= '0;
      col_q      <= '0;
      kind_q     <= K_IDLE;
      read_act_q <= 1'b0;
      dq_oe      <= 1'b0;
      ref_cnt    <= '0;
      refr_row   <= '0;
      proto_err  <= 1'b0;
    end else begin
      kind_q     <= kind_d;
      read_act_q <= read_act_d;
      dq_oe      <= read_act_d & ~oe_n;
      if (open_evt) begin
        row_q    <= addr;
        refr_row <= addr;
      end
      if (cas_fall) col_q <= addr;
      if (cbr_evt) begin
        refr_row <= ref_cnt;
        ref_cnt  <= ref_cnt + 1'b1;
      end
      if (lw_evt && !oe_n && dq_oe) proto_err <= 1'b1;
    end
  end

  assign cyc_kind = kind_q;

endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int DQ_W  = 16,
  parameter int IDX_W = 6,
  localparam int LANES = DQ_W / 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             rd_load,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        rd_q <= '0;
      end else begin
        if (wr_en && wr_lanes[ln]) mem[wr_idx] <= wr_data[ln*8 +: 8];
        if (rd_load) rd_q <= mem[rd_idx];
      end
    end

    assign rd_data[ln*8 +: 8] = rd_q;
  end

endmodule

// File: rtl/byte_lane_dram.sv
module byte_lane_dram #(
  parameter int ADDR_W    = 8,
  parameter int DQ_W      = 16,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              casl_n,
  input  logic              cash_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] ref_cnt,
  output logic [ADDR_W-1:0] refr_row,
  output logic              proto_err
);
  localparam int IDX_W = ROW_IDX_W + COL_IDX_W;

  logic cas_n, cas_prev_n, ras_fall, cas_fall, we_fall, cycle_end;
  logic rd_evt, ew_evt, lw_evt, cbr_evt, wr_en;
  logic [1:0]       wr_lanes;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  strobe_sampler u_sampler (
    .clk, .rst_n, .ras_n, .casl_n, .cash_n, .we_n,
    .cas_n, .cas_prev_n, .ras_fall, .cas_fall, .we_fall, .cycle_end
  );

  cycle_classifier #(
    .ADDR_W(ADDR_W), .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W)
  ) u_class (
    .clk, .rst_n, .ras_n, .cas_n, .cas_prev_n, .casl_n, .cash_n, .we_n, .oe_n,
    .addr, .ras_fall, .cas_fall, .we_fall, .cycle_end,
    .rd_evt, .ew_evt, .lw_evt, .cbr_evt, .wr_en, .wr_lanes, .wr_idx, .rd_idx,
    .dq_oe, .cyc_kind, .ref_cnt, .refr_row, .proto_err
  );

  lane_array #(.DQ_W(DQ_W), .IDX_W(IDX_W)) u_array (
    .clk, .rst_n, .wr_en, .wr_lanes, .wr_idx, .wr_data(dq_in),
    .rd_load(rd_evt), .rd_idx, .rd_data(dq_out)
  );

endmodule

// File: rtl/byte_lane_dram_chk.sv
module byte_lane_dram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              casl_n,
  input logic              cash_n,
  input logic              oe_n,
  input logic              ew_evt,
  input logic              dq_oe,
  input logic [2:0]        cyc_kind,
  input logic [ADDR_W-1:0] ref_cnt,
  input logic              proto_err
);

  AST_EARLY_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd2) |-> !dq_oe); // R4

  AST_EARLY_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ew_evt |=> !dq_oe); // R4

  AST_LATE_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd3) |-> !dq_oe); // R5

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt != $past(ref_cnt)) |-> (ref_cnt == ADDR_W'($past(ref_cnt) + 1'b1))); // R7

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe); // R9

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && casl_n && cash_n) |=> !dq_oe); // R10

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R12

endmodule

bind byte_lane_dram byte_lane_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
  .oe_n(oe_n), .ew_evt(ew_evt), .dq_oe(dq_oe), .cyc_kind(cyc_kind),
  .ref_cnt(ref_cnt), .proto_err(proto_err)
);

// File: tb/byte_lane_dram_bench.sv
`timescale 1ns/1ps
module byte_lane_dram_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [2:0]  cyc_kind;
  logic [7:0]  ref_cnt, refr_row;
  logic        proto_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_lane_dram u_byte_lane_dram (
    .clk, .rst_n, .ras_n, .casl_n, .cash_n, .we_n, .oe_n, .addr, .dq_in,
    .dq_out, .dq_oe, .cyc_kind, .ref_cnt, .refr_row, .proto_err
  );

  typedef struct packed {
    logic        r, cl, ch, w, o;
    logic [7:0]  a;
    logic [15:0] d;
    logic [2:0]  k;
    logic        oe;
    logic        chk;
    logic [15:0] q;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{0,1,1,1,1, 8'h02, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,1,1,0,1, 8'h05, 16'hA5A5, 3'd5, 0, 0, 16'h0000, 4'd4},
    '{0,0,0,0,1, 8'h05, 16'hA5A5, 3'd2, 0, 0, 16'h0000, 4'd4},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd2, 0, 0, 16'h0000, 4'd4},
    '{0,1,1,1,1, 8'h02, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,0,1,0, 8'h05, 16'h0000, 3'd1, 1, 1, 16'hA5A5, 4'd3},
    '{1,1,1,1,0, 8'h00, 16'h0000, 3'd1, 0, 1, 16'hA5A5, 4'd10},
    '{0,1,1,1,1, 8'h02, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,1,0,0,1, 8'h05, 16'h3C3C, 3'd2, 0, 0, 16'h0000, 4'd6},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd2, 0, 0, 16'h0000, 4'd6},
    '{0,1,1,1,1, 8'h02, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,1,1,0, 8'h05, 16'h0000, 3'd1, 1, 1, 16'h3CA5, 4'd1},
    '{0,1,0,1,0, 8'h05, 16'h0000, 3'd1, 1, 1, 16'h3CA5, 4'd1},
    '{1,1,0,1,0, 8'h00, 16'h0000, 3'd1, 1, 1, 16'h3CA5, 4'd10},
    '{1,1,1,1,0, 8'h00, 16'h0000, 3'd1, 0, 0, 16'h0000, 4'd10},
    '{0,1,1,1,1, 8'h03, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,0,1,1, 8'h01, 16'h0000, 3'd1, 0, 1, 16'h0000, 4'd2},
    '{0,0,0,0,1, 8'h01, 16'h1234, 3'd3, 0, 0, 16'h0000, 4'd5},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd3, 0, 0, 16'h0000, 4'd5},
    '{0,1,1,1,1, 8'h03, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,0,1,0, 8'h01, 16'h0000, 3'd1, 1, 1, 16'h1234, 4'd5},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd1, 0, 0, 16'h0000, 4'd10},
    '{0,1,1,1,1, 8'h03, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,1,1,1, 8'h01, 16'h0000, 3'd1, 0, 1, 16'h1234, 4'd3},
    '{0,0,1,0,1, 8'h01, 16'hFFFF, 3'd3, 0, 0, 16'h0000, 4'd6},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd3, 0, 0, 16'h0000, 4'd6},
    '{0,1,1,1,1, 8'h03, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd2},
    '{0,0,0,1,0, 8'h01, 16'h0000, 3'd1, 1, 1, 16'h12FF, 4'd6},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd1, 0, 0, 16'h0000, 4'd10},
    '{0,1,1,1,1, 8'h77, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd8},
    '{1,1,1,1,1, 8'h00, 16'h0000, 3'd5, 0, 0, 16'h0000, 4'd8}
  };

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive just after an edge, read 1 ns after the next edge
  task automatic step(input logic r, cl, ch, w, o, input logic [7:0] a, input logic [15:0] d);
    ras_n = r; casl_n = cl; cash_n = ch; we_n = w; oe_n = o; addr = a; dq_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1, 1, 1, 1, 1, 8'h00, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R13 reset state
    check("R13 kind", cyc_kind, 0);
    check("R13 oe", dq_oe, 0);
    check("R13 dq", dq_out, 0);
    check("R13 ref_cnt", ref_cnt, 0);
    check("R13 refr_row", refr_row, 0);
    check("R13 err", proto_err, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].r, VEC[i].cl, VEC[i].ch, VEC[i].w, VEC[i].o, VEC[i].a, VEC[i].d);
      check(req_name(VEC[i].tag), cyc_kind, VEC[i].k);
      check(req_name(VEC[i].tag), dq_oe, VEC[i].oe);
      if (VEC[i].chk) check(req_name(VEC[i].tag), dq_out, VEC[i].q);
    end
    check("R8 counter kept", ref_cnt, 0);
    check("R8 refr_row pins", refr_row, 8'h77);

    // R7 counter refresh, twice
    step(1, 0, 0, 1, 1, 8'h00, 16'h0000);
    step(0, 0, 0, 1, 1, 8'h99, 16'h0000);
    check("R7 kind", cyc_kind, 4);
    check("R7 refr_row", refr_row, 0);
    check("R7 ref_cnt", ref_cnt, 1);
    idle();
    step(1, 0, 0, 1, 1, 8'h00, 16'h0000);
    step(0, 0, 0, 1, 1, 8'h44, 16'h0000);
    check("R7 refr_row 2nd", refr_row, 1);
    check("R7 ref_cnt 2nd", ref_cnt, 2);
    idle();

    // R8 row-address refresh
    step(0, 1, 1, 1, 1, 8'h55, 16'h0000);
    check("R8 kind", cyc_kind, 5);
    check("R8 refr_row", refr_row, 8'h55);
    check("R8 ref_cnt", ref_cnt, 2);
    idle();

    // R11 hidden refresh after a read of word {2,5}
    step(0, 1, 1, 1, 1, 8'h02, 16'h0000);
    step(0, 0, 0, 1, 0, 8'h05, 16'h0000);
    check("R11 read oe", dq_oe, 1);
    step(1, 0, 0, 1, 0, 8'h00, 16'h0000);
    check("R11 ras high oe", dq_oe, 1);
    step(0, 0, 0, 1, 0, 8'h00, 16'h0000);
    check("R11 kind", cyc_kind, 4);
    check("R11 oe", dq_oe, 1);
    check("R11 dq", dq_out, 16'h3CA5);
    check("R11 ref_cnt", ref_cnt, 3);
    step(1, 0, 0, 1, 0, 8'h00, 16'h0000);
    check("R11 still driven", dq_oe, 1);
    step(1, 1, 1, 1, 0, 8'h00, 16'h0000);
    check("R10 release", dq_oe, 0);

    // R9 output enable withdrawn mid-read
    step(0, 1, 1, 1, 1, 8'h02, 16'h0000);
    step(0, 0, 0, 1, 0, 8'h05, 16'h0000);
    check("R9 on", dq_oe, 1);
    step(0, 0, 0, 1, 1, 8'h05, 16'h0000);
    check("R9 off", dq_oe, 0);
    check("R12 no err yet", proto_err, 0);
    idle();

    // R12 write capture while driving
    step(0, 1, 1, 1, 1, 8'h02, 16'h0000);
    step(0, 0, 0, 1, 0, 8'h05, 16'h0000);
    check("R12 driving", dq_oe, 1);
    step(0, 0, 0, 0, 0, 8'h05, 16'hBEEF);
    check("R12 err set", proto_err, 1);
    check("R5 kind on err", cyc_kind, 3);
    idle();
    check("R12 err sticky", proto_err, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule